// File: doc/BRIEF.md
# Multi-Cycle Instruction Control Sequencer

This block is the control unit of a small 16-bit load/store processor whose program counter is general register R7. It watches the instruction register, the interrupt-enable bit, a branch-condition result and an interrupt request. It steps through a fetch pair and then one to three execute states. In each state it drives the selects and strobes that the register file, the ALU and an external memory host need.

The register datapath, the ALU and the memory host sit outside the block. The save and restore of PC and status on an interrupt belongs to a separate sequencer. This block starts that sequencer (`irq_go` for an interrupt, `iret_go` for a return) and waits for `xfer_done` before it resumes. Because the PC is an ordinary register, returns and table jumps need no special opcodes. A PC-relative load with zero offset reads an inline literal and spends one more cycle stepping the PC past it.

Top module: `rsq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the block sits in its first reset state with every strobe and write enable low. The first edge with `rst` low enters a second reset state, still with no strobes. The next edge begins an instruction fetch.
- R2: Fetch takes two cycles. In the first, `mem_rd`, `mem_word` and `bus_drive` are high, `rd_a_sel`=7 and `alu_fn`=1 (pass A). In the second, `ir_ld` and `pc_we` are high, `rd_a_sel`=7, `alu_fn`=0 (add) and `alu_b_src`=3 (constant two).
- R3: Major opcode IR[15:13]=001 executes in one cycle. It sets `rd_a_sel`=IR[12:10], `rd_b_sel`=IR[6:4], `wr_sel`=IR[9:7], `rf_we`=1, `cc_we`=1, `alu_fn`=3 (minor op) and `alu_minor`=IR[3:0].
- R4: Major 000 with {IR[12:10],IR[0]} non-zero is a branch. For one cycle it sets `rd_a_sel`=7, `alu_b_src`=2 (word displacement) and `alu_fn`=0, and `pc_we` follows `branch_true`.
- R5: Major 010 is a load. Its first cycle sets `rd_a_sel`=IR[12:10], `alu_b_src`=1 (7-bit offset), `mem_rd`=1 and `mem_word`=IR[0]. Its second cycle sets `rf_we`=1, `wr_from_mem`=1 and `wr_sel`=IR[9:7].
- R6: A load with IR[12:10]=7 and IR[6:0]=0 adds a third cycle with `pc_we`=1, `rd_a_sel`=7, `alu_b_src`=3 and `alu_fn`=0. Any other load goes straight back to fetch.
- R7: Major 011 is a store. Its first cycle sets `mem_wr`=1, `mem_word`=IR[0], `alu_b_src`=1 and `rd_a_sel`=IR[12:10]. Its second cycle sets `rd_b_sel`=IR[9:7], `alu_fn`=2 (pass B) and `bus_drive`=1, with no memory strobe.
- R8: Major 100 writes A plus offset to D in one cycle (`rf_we`=1, `wr_from_mem`=0, `alu_b_src`=1) and raises no memory strobe.
- R9: A halt is either major 000 with IR[12:10], IR[2:0] all zero, or any major from 101 to 111. For one cycle it raises `halt` and `bus_drive` with `rd_b_sel`=IR[6:4] and `alu_fn`=2, then fetches again.
- R10: Misc code IR[2:1]=10 writes status from B (`ps_we`=1, `rd_b_sel`=IR[6:4], `alu_fn`=2). Code 11 reads status into D (`alu_a_src`=1, `alu_fn`=1, `rf_we`=1, `wr_sel`=IR[9:7]).
- R11: Misc code IR[2:1]=01 holds `iret_go` high until a cycle with `xfer_done` high, then continues at an instruction boundary.
- R12: At each instruction boundary, an `irq` with `ps_ie` high holds `irq_go` high in place of a fetch until `xfer_done`, and fetch follows. With `ps_ie` low the request is ignored, and a request never cuts a multi-cycle instruction short.
- R13: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ir_q | input | 16 | Current instruction register contents |
| ps_ie | input | 1 | Interrupt-enable bit of the status word |
| irq | input | 1 | Interrupt request |
| branch_true | input | 1 | Branch condition met, from condition logic |
| xfer_done | input | 1 | Interrupt save/restore sequencer finished |
| rd_a_sel | output | 3 | Register read port A select |
| rd_b_sel | output | 3 | Register read port B select |
| wr_sel | output | 3 | Register write select |
| rf_we | output | 1 | Register write enable |
| wr_from_mem | output | 1 | Write data from memory instead of ALU |
| pc_we | output | 1 | Write ALU result to R7 |
| alu_fn | output | 2 | 0 add, 1 pass A, 2 pass B, 3 minor op |
| alu_minor | output | 4 | Minor opcode during arithmetic, else 0 |
| alu_a_src | output | 2 | 0 register, 1 status word |
| alu_b_src | output | 2 | 0 register, 1 byte offset, 2 word displacement, 3 constant two |
| cc_we | output | 1 | Update condition codes |
| ps_we | output | 1 | Write status word |
| ir_ld | output | 1 | Latch instruction register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_word | output | 1 | Word (1) or byte (0) access |
| bus_drive | output | 1 | ALU result drives the host bus |
| halt | output | 1 | Halt strobe to host |
| irq_go | output | 1 | Start interrupt save sequence |
| iret_go | output | 1 | Start interrupt restore sequence |

## Verification
The bench builds the block with the package defaults: a 16-bit instruction word and R7 as the program counter. With these values the zero-offset PC load and its extra step cycle can be reached, and so can the case of a load through R7 with a non-zero offset, which must skip that cycle. The bench also exercises a branch whose condition sits only in IR[0], the halt reached through the unused high majors, and an interrupt raised mid-load, which must wait for the load's last cycle.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    localparam int IR_W    = 16;
    localparam int SEL_W   = 3;
    localparam int MINOR_W = 4;
    localparam int MAJ_W   = 3;
    localparam int OFS_W   = 7;
    localparam logic [SEL_W-1:0] PC_IDX = SEL_W'(7);

    typedef enum logic [1:0] {
        FN_ADD    = 2'd0,
        FN_PASS_A = 2'd1,
        FN_PASS_B = 2'd2,
        FN_MINOR  = 2'd3
    } alu_fn_e;

    typedef enum logic [1:0] {
        ASRC_REG = 2'd0,
        ASRC_PS  = 2'd1
    } a_src_e;

    typedef enum logic [1:0] {
        BSRC_REG  = 2'd0,
        BSRC_OFS  = 2'd1,
        BSRC_DISP = 2'd2,
        BSRC_TWO  = 2'd3
    } b_src_e;

    typedef enum logic [4:0] {
        ST_RST0, ST_RST1, ST_FETCH1, ST_FETCH2, ST_BCC1, ST_ARITH1,
        ST_LDA1, ST_LOAD1, ST_LOAD2, ST_LOAD3, ST_STORE1, ST_STORE2,
        ST_RDPS1, ST_WRPS1, ST_HALT1, ST_IRQH, ST_IRETH
    } seq_st_e;

    typedef enum logic [3:0] {
        IC_BCC, IC_ARITH, IC_LOAD, IC_STORE, IC_LDA,
        IC_HALT, IC_IRET, IC_WRPS, IC_RDPS
    } iclass_e;

    typedef struct packed {
        iclass_e              cls;
        logic [SEL_W-1:0]     ra;
        logic [SEL_W-1:0]     rd;
        logic [SEL_W-1:0]     rb;
        logic [MINOR_W-1:0]   minor;
        logic                 word;
        logic                 pc_imm;
    } dec_t;

    typedef struct packed {
        logic [SEL_W-1:0]   rd_a;
        logic [SEL_W-1:0]   rd_b;
        logic [SEL_W-1:0]   wsel;
        logic               rf_we;
        logic               wr_mem;
        logic               pc_we;
        alu_fn_e            fn;
        logic [MINOR_W-1:0] minor;
        a_src_e             asrc;
        b_src_e             bsrc;
        logic               cc_we;
        logic               ps_we;
        logic               ir_ld;
        logic               mem_rd;
        logic               mem_wr;
        logic               mem_word;
        logic               bus_drive;
        logic               halt;
        logic               irq_go;
        logic               iret_go;
    } ctrl_t;

    function automatic iclass_e misc_class(input logic [1:0] code);
        case (code)
            2'b00:   return IC_HALT;
            2'b01:   return IC_IRET;
            2'b10:   return IC_WRPS;
            default: return IC_RDPS;
        endcase
    endfunction

    function automatic seq_st_e first_state(input iclass_e c);
        case (c)
            IC_BCC:   return ST_BCC1;
            IC_ARITH: return ST_ARITH1;
            IC_LOAD:  return ST_LOAD1;
            IC_STORE: return ST_STORE1;
            IC_LDA:   return ST_LDA1;
            IC_IRET:  return ST_IRETH;
            IC_WRPS:  return ST_WRPS1;
            IC_RDPS:  return ST_RDPS1;
            default:  return ST_HALT1;
        endcase
    endfunction

endpackage

// File: rtl/rsq_decode.sv
module rsq_decode
    import rsq_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output dec_t            dec
);
    localparam int MAJ_LO = IR_W - MAJ_W;

    logic [MAJ_W-1:0] major;
    logic [3:0]       cond;

    assign major = ir[IR_W-1:MAJ_LO];
    assign cond  = {ir[12:10], ir[0]};

    always_comb begin
        dec.ra     = ir[12:10];
        dec.rd     = ir[9:7];
        dec.rb     = ir[6:4];
        dec.minor  = ir[MINOR_W-1:0];
        dec.word   = ir[0];
        dec.pc_imm = (ir[12:10] == PC_IDX) && (ir[OFS_W-1:0] == '0);
        case (major)
            3'b000:  dec.cls = (cond != 4'd0) ? IC_BCC : misc_class(ir[2:1]);
            3'b001:  dec.cls = IC_ARITH;
            3'b010:  dec.cls = IC_LOAD;
            3'b011:  dec.cls = IC_STORE;
            3'b100:  dec.cls = IC_LDA;
            default: dec.cls = IC_HALT;
        endcase
    end

endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
    import rsq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  iclass_e cls,
    input  logic    pc_imm,
    input  logic    ps_ie,
    input  logic    irq,
    input  logic    xfer_done,
    output seq_st_e state
);
    seq_st_e nxt;
    seq_st_e at_boundary;

    assign at_boundary = (irq && ps_ie) ? ST_IRQH : ST_FETCH1;

    always_comb begin
        nxt = state;
        case (state)
            ST_RST0:   nxt = ST_RST1;
            ST_RST1:   nxt = at_boundary;
            ST_FETCH1: nxt = ST_FETCH2;
            ST_FETCH2: nxt = first_state(cls);
            ST_LOAD1:  nxt = ST_LOAD2;
            ST_LOAD2:  nxt = pc_imm ? ST_LOAD3 : at_boundary;
            ST_STORE1: nxt = ST_STORE2;
            ST_IRQH:   nxt = xfer_done ? ST_FETCH1 : ST_IRQH;
            ST_IRETH:  nxt = xfer_done ? at_boundary : ST_IRETH;
            default:   nxt = at_boundary;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_RST0;
        else     state <= nxt;
    end

    AST_RST_HOLD: assert property (@(posedge clk) rst |=> (state == ST_RST0)); // R1
    AST_FETCH_PAIR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH1) |=> (state == ST_FETCH2)); // R2
    AST_LOAD3_AFTER_LOAD2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD3) |-> ($past(state) == ST_LOAD2)); // R6
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IRQH && $past(state) != ST_IRQH) |-> $past(irq && ps_ie)); // R12

endmodule

// File: rtl/rsq_ctrl_out.sv
module rsq_ctrl_out
    import rsq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  seq_st_e            state,
    input  logic [SEL_W-1:0]   ra,
    input  logic [SEL_W-1:0]   rd,
    input  logic [SEL_W-1:0]   rb,
    input  logic [MINOR_W-1:0] minor,
    input  logic               word,
    input  logic               branch_true,
    output ctrl_t              c
);
    always_comb begin
        c = '0;
        case (state)
            ST_FETCH1: begin
                c.rd_a = PC_IDX;  c.fn = FN_PASS_A;
                c.mem_rd = 1'b1;  c.mem_word = 1'b1;  c.bus_drive = 1'b1;
            end
            ST_FETCH2: begin
                c.ir_ld = 1'b1;   c.rd_a = PC_IDX;
                c.bsrc = BSRC_TWO; c.fn = FN_ADD;   c.pc_we = 1'b1;
            end
            ST_BCC1: begin
                c.rd_a = PC_IDX;  c.bsrc = BSRC_DISP; c.fn = FN_ADD;
                c.pc_we = branch_true;
            end
            ST_ARITH1: begin
                c.rd_a = ra;  c.rd_b = rb;  c.wsel = rd;  c.rf_we = 1'b1;
                c.fn = FN_MINOR;  c.minor = minor;  c.cc_we = 1'b1;
            end
            ST_LDA1: begin
                c.rd_a = ra;  c.bsrc = BSRC_OFS;  c.fn = FN_ADD;
                c.wsel = rd;  c.rf_we = 1'b1;
            end
            ST_LOAD1: begin
                c.rd_a = ra;  c.bsrc = BSRC_OFS;  c.fn = FN_ADD;
                c.mem_rd = 1'b1;  c.mem_word = word;  c.bus_drive = 1'b1;
            end
            ST_LOAD2: begin
                c.wsel = rd;  c.rf_we = 1'b1;  c.wr_mem = 1'b1;  c.mem_word = word;
            end
            ST_LOAD3: begin
                c.rd_a = PC_IDX;  c.bsrc = BSRC_TWO;  c.fn = FN_ADD;  c.pc_we = 1'b1;
            end
            ST_STORE1: begin
                c.rd_a = ra;  c.bsrc = BSRC_OFS;  c.fn = FN_ADD;
                c.mem_wr = 1'b1;  c.mem_word = word;  c.bus_drive = 1'b1;
            end
            ST_STORE2: begin
                c.rd_b = rd;  c.fn = FN_PASS_B;  c.mem_word = word;  c.bus_drive = 1'b1;
            end
            ST_RDPS1: begin
                c.asrc = ASRC_PS;  c.fn = FN_PASS_A;  c.wsel = rd;  c.rf_we = 1'b1;
            end
            ST_WRPS1: begin
                c.rd_b = rb;  c.fn = FN_PASS_B;  c.ps_we = 1'b1;
            end
            ST_HALT1: begin
                c.rd_b = rb;  c.fn = FN_PASS_B;  c.halt = 1'b1;  c.bus_drive = 1'b1;
            end
            ST_IRQH:  c.irq_go  = 1'b1;
            ST_IRETH: c.iret_go = 1'b1;
            default:  c = '0;
        endcase
    end

    AST_MEM_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(c.mem_rd && c.mem_wr)); // R13
    AST_IRLD_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
        c.ir_ld |-> $past(c.mem_rd && c.mem_word)); // R2
    AST_STORE_DATA: assert property (@(posedge clk) disable iff (rst)
        c.mem_wr |=> (c.bus_drive && !c.mem_wr && !c.mem_rd)); // R7
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !(c.mem_rd || c.mem_wr || c.rf_we || c.pc_we || c.halt)); // R1

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
    import rsq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] ir_q,
    input  logic        ps_ie,
    input  logic        irq,
    input  logic        branch_true,
    input  logic        xfer_done,
    output logic [2:0]  rd_a_sel,
    output logic [2:0]  rd_b_sel,
    output logic [2:0]  wr_sel,
    output logic        rf_we,
    output logic        wr_from_mem,
    output logic        pc_we,
    output logic [1:0]  alu_fn,
    output logic [3:0]  alu_minor,
    output logic [1:0]  alu_a_src,
    output logic [1:0]  alu_b_src,
    output logic        cc_we,
    output logic        ps_we,
    output logic        ir_ld,
    output logic        mem_rd,
    output logic        mem_wr,
    output logic        mem_word,
    output logic        bus_drive,
    output logic        halt,
    output logic        irq_go,
    output logic        iret_go
);
    dec_t    dec;
    seq_st_e state;
    ctrl_t   c;

    rsq_decode u_dec (
        .ir  (ir_q),
        .dec (dec)
    );

    rsq_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cls       (dec.cls),
        .pc_imm    (dec.pc_imm),
        .ps_ie     (ps_ie),
        .irq       (irq),
        .xfer_done (xfer_done),
        .state     (state)
    );

    rsq_ctrl_out u_out (
        .clk         (clk),
        .rst         (rst),
        .state       (state),
        .ra          (dec.ra),
        .rd          (dec.rd),
        .rb          (dec.rb),
        .minor       (dec.minor),
        .word        (dec.word),
        .branch_true (branch_true),
        .c           (c)
    );

    assign rd_a_sel    = c.rd_a;
    assign rd_b_sel    = c.rd_b;
    assign wr_sel      = c.wsel;
    assign rf_we       = c.rf_we;
    assign wr_from_mem = c.wr_mem;
    assign pc_we       = c.pc_we;
    assign alu_fn      = c.fn;
    assign alu_minor   = c.minor;
    assign alu_a_src   = c.asrc;
    assign alu_b_src   = c.bsrc;
    assign cc_we       = c.cc_we;
    assign ps_we       = c.ps_we;
    assign ir_ld       = c.ir_ld;
    assign mem_rd      = c.mem_rd;
    assign mem_wr      = c.mem_wr;
    assign mem_word    = c.mem_word;
    assign bus_drive   = c.bus_drive;
    assign halt        = c.halt;
    assign irq_go      = c.irq_go;
    assign iret_go     = c.iret_go;

    AST_HANDOFF_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(irq_go && iret_go)); // R11
    AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        halt |=> !halt); // R9

endmodule

// File: tb/rsq_ctrl_test.sv
`timescale 1ns/1ps
module rsq_ctrl_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] ir_q = '0;
    logic ps_ie = 1'b0, irq = 1'b0, branch_true = 1'b0, xfer_done = 1'b0;
    logic [2:0] rd_a_sel, rd_b_sel, wr_sel;
    logic rf_we, wr_from_mem, pc_we, cc_we, ps_we, ir_ld;
    logic [1:0] alu_fn, alu_a_src, alu_b_src;
    logic [3:0] alu_minor;
    logic mem_rd, mem_wr, mem_word, bus_drive, halt, irq_go, iret_go;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    rsq_ctrl uut (
        .clk(clk), .rst(rst), .ir_q(ir_q), .ps_ie(ps_ie), .irq(irq),
        .branch_true(branch_true), .xfer_done(xfer_done),
        .rd_a_sel(rd_a_sel), .rd_b_sel(rd_b_sel), .wr_sel(wr_sel),
        .rf_we(rf_we), .wr_from_mem(wr_from_mem), .pc_we(pc_we),
        .alu_fn(alu_fn), .alu_minor(alu_minor), .alu_a_src(alu_a_src),
        .alu_b_src(alu_b_src), .cc_we(cc_we), .ps_we(ps_we), .ir_ld(ir_ld),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_word(mem_word),
        .bus_drive(bus_drive), .halt(halt), .irq_go(irq_go), .iret_go(iret_go)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic int strobes();
        return {mem_rd, mem_wr, rf_we, pc_we, halt, ir_ld, cc_we, ps_we, irq_go, iret_go};
    endfunction

    task automatic chk_fetch1(input string req);
        chk(req, "fetch1 mem_rd", mem_rd, 1);
        chk(req, "fetch1 word/drive/rdA/fn", {mem_word, bus_drive, rd_a_sel, alu_fn}, {1'b1, 1'b1, 3'd7, 2'd1});
        chk(req, "fetch1 no irq_go/ir_ld", {irq_go, ir_ld}, 0);
    endtask

    task automatic fetch(input logic [15:0] ir);
        chk_fetch1("R2");
        ir_q = ir;
        step();
        chk("R2", "fetch2 ir_ld/pc_we", {ir_ld, pc_we}, 2'b11);
        chk("R2", "fetch2 rdA/bsrc/fn", {rd_a_sel, alu_b_src, alu_fn}, {3'd7, 2'd3, 2'd0});
        step();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step(); step();
        chk("R1", "strobes in reset", strobes(), 0);
        rst = 1'b0;
        step();
        chk("R1", "strobes in second reset state", strobes(), 0);
        step();
        chk_fetch1("R1");
    endtask

    task automatic t_arith();
        fetch(16'h3569); // A=5 D=2 B=6 minor=9
        chk("R3", "sels", {rd_a_sel, rd_b_sel, wr_sel}, {3'd5, 3'd6, 3'd2});
        chk("R3", "we/cc/fn/minor", {rf_we, cc_we, alu_fn, alu_minor}, {1'b1, 1'b1, 2'd3, 4'd9});
        chk("R3", "no mem", {mem_rd, mem_wr}, 0);
        step();
        chk_fetch1("R3");
    endtask

    task automatic t_branch(input logic [15:0] ir, input logic taken);
        fetch(ir);
        branch_true = taken;
        #0.5;
        chk("R4", "rdA/bsrc/fn", {rd_a_sel, alu_b_src, alu_fn}, {3'd7, 2'd2, 2'd0});
        chk("R4", "pc_we follows condition", pc_we, taken);
        chk("R4", "no halt/misc", {halt, iret_go, ps_we}, 0);
        step();
        branch_true = 1'b0;
        chk_fetch1("R4");
    endtask

    task automatic t_load(input logic [15:0] ir, input logic third);
        fetch(ir);
        chk("R5", "load1 rdA/bsrc/fn", {rd_a_sel, alu_b_src, alu_fn}, {ir[12:10], 2'd1, 2'd0});
        chk("R5", "load1 rd/word", {mem_rd, mem_wr, mem_word}, {1'b1, 1'b0, ir[0]});
        step();
        chk("R5", "load2 write from mem", {rf_we, wr_from_mem, wr_sel}, {1'b1, 1'b1, ir[9:7]});
        chk("R5", "load2 no strobe", {mem_rd, mem_wr, pc_we}, 0);
        step();
        if (third) begin
            chk("R6", "load3 pc step", {pc_we, rd_a_sel, alu_b_src, alu_fn}, {1'b1, 3'd7, 2'd3, 2'd0});
            chk("R6", "load3 no mem/rf", {mem_rd, rf_we}, 0);
            step();
        end
        chk_fetch1(third ? "R6" : "R5");
    endtask

    task automatic t_store();
        fetch(16'h6AC1); // A=2 D=5 ofs=0x41 word
        chk("R7", "store1", {mem_wr, mem_rd, mem_word, alu_b_src, rd_a_sel}, {1'b1, 1'b0, 1'b1, 2'd1, 3'd2});
        step();
        chk("R7", "store2 data", {rd_b_sel, alu_fn, bus_drive}, {3'd5, 2'd2, 1'b1});
        chk("R7", "store2 no strobe", {mem_rd, mem_wr, rf_we}, 0);
        step();
        chk_fetch1("R7");
    endtask

    task automatic t_lda();
        fetch(16'h877F); // A=1 D=6
        chk("R8", "lda write", {rf_we, wr_from_mem, wr_sel, alu_b_src, rd_a_sel}, {1'b1, 1'b0, 3'd6, 2'd1, 3'd1});
        chk("R8", "lda no mem", {mem_rd, mem_wr}, 0);
        step();
        chk_fetch1("R8");
    endtask

    task automatic t_halt(input logic [15:0] ir);
        fetch(ir);
        chk("R9", "halt", {halt, bus_drive, rd_b_sel, alu_fn}, {1'b1, 1'b1, ir[6:4], 2'd2});
        chk("R9", "halt no writes", {rf_we, pc_we, mem_rd, mem_wr}, 0);
        step();
        chk_fetch1("R9");
        chk("R9", "halt released", halt, 0);
    endtask

    task automatic t_ps();
        fetch(16'h0054); // WRPS B=5
        chk("R10", "wrps", {ps_we, rd_b_sel, alu_fn, rf_we}, {1'b1, 3'd5, 2'd2, 1'b0});
        step();
        chk_fetch1("R10");
        fetch(16'h0186); // RDPS D=3
        chk("R10", "rdps", {alu_a_src, alu_fn, rf_we, wr_sel, ps_we}, {2'd1, 2'd1, 1'b1, 3'd3, 1'b0});
        step();
        chk_fetch1("R10");
    endtask

    task automatic t_iret();
        fetch(16'h0002);
        chk("R11", "iret_go", iret_go, 1);
        step(); step();
        chk("R11", "iret_go held", {iret_go, mem_rd}, 2'b10);
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
        chk_fetch1("R11");
        chk("R11", "iret_go dropped", iret_go, 0);
    endtask

    task automatic t_irq();
        fetch(16'h4E15);
        ps_ie = 1'b1; irq = 1'b1;
        step();
        chk("R12", "load2 not cut", {rf_we, wr_from_mem, irq_go}, 3'b110);
        step();
        chk("R12", "irq_go at boundary", {irq_go, mem_rd}, 2'b10);
        step();
        chk("R12", "irq_go held", irq_go, 1);
        xfer_done = 1'b1; irq = 1'b0; ps_ie = 1'b0;
        step();
        xfer_done = 1'b0;
        chk_fetch1("R12");
        // masked request
        fetch(16'h3569);
        irq = 1'b1;
        step();
        chk("R12", "masked irq ignored", irq_go, 0);
        chk_fetch1("R12");
        irq = 1'b0;
    endtask

    initial begin
        #1;
        t_reset();
        t_arith();
        t_branch(16'h0806, 1'b1);
        t_branch(16'h0806, 1'b0);
        t_branch(16'h0001, 1'b1);   // condition only in IR[0]
        t_load(16'h4E15, 1'b0);
        t_load(16'h5C80, 1'b1);     // PC-relative, zero offset
        t_load(16'h5C81, 1'b0);     // PC base, non-zero offset
        t_store();
        t_lda();
        t_halt(16'h0030);
        t_halt(16'hE050);
        t_ps();
        t_iret();
        t_irq();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule